// File: doc/BRIEF.md
# Host Memory Window Gate

This block stands between a host register bus and a 4 KiB data memory that belongs to an accelerator. It controls which host accesses reach that memory. The host can reach only the lower 2 KiB, and only while the accelerator is not running. The upper half is kept private to the accelerator, so the host cannot read anything stored there.

Every word the host writes into the window is also folded into a running CRC-32 checksum. Before a load, the host seeds the checksum through a small register area. After the load, it reads the checksum back to check that the load was intact. A status register in the same area reports whether the accelerator is busy.

Address bit 12 selects the area: 0 selects the memory, 1 selects the registers. Every request receives exactly one response one cycle later. The response carries read data and an error flag. A rejected request never changes the memory or the checksum.

Top module: `hostmem_gate`

## Requirements
- R1: When `busy_i` is low, an aligned full-word request to a byte offset in 0x000..0x7FF with `addr_i[12]`=0 is accepted. A write stores `wdata_i` at word offset/4. A read returns the stored word in the response cycle with `err_o`=0.
- R2: A memory-area request to an offset at or above 0x800 is rejected. It sets `err_o`, returns zero and leaves both the lower-half memory contents and the checksum unchanged.
- R3: While `busy_i` is high, a memory-area request is rejected. It sets `err_o`, returns zero, discards write data and leaves the checksum unchanged.
- R4: A request whose `addr_i[1:0]` is nonzero, or whose `be_i` is not 4'hF, is rejected with `err_o`. It changes neither the memory nor the checksum.
- R5: Each accepted memory write updates the checksum C to crc(C, D). To compute crc(C, D), take X = C xor D, then repeat 32 times: if X[0] is 1, X becomes (X>>1) xor 0xEDB88320; otherwise X becomes X>>1.
- R6: The checksum register sits at address 0x1004. A write there replaces the checksum with `wdata_i`, and a read returns its current value. Access is allowed whether busy or not.
- R7: The status register sits at address 0x1000. A read returns `busy_i` at the time of the request in bit 0, with all other bits zero. A write to it has no effect and no error.
- R8: Every request gets exactly one `rsp_valid_o` pulse in the next cycle, and no response appears without a request. Register-area addresses other than 0x1000 and 0x1004 respond with `err_o`. An error response always carries zero data.
- R9: After reset the checksum is zero and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Accelerator running; blocks memory access |
| req_i | input | 1 | Host request strobe, one cycle per request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Byte address; bit 12 selects register area |
| be_i | input | 4 | Byte enables; must be all ones |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response pulse, one cycle after a request |
| rdata_o | output | 32 | Read data, zero on writes and errors |
| err_o | output | 1 | Request rejected |

## Verification
Every word of the lower window is written with a distinct arithmetic pattern and then read back. This catches index slicing or write-enable faults. The checksum is compared after the full sweep, so a wrong fold order or polynomial shows up. Upper-half addresses are swept next, followed by a full reread of the lower half. That reread tells a correct rejection apart from an aliasing write that drops the top offset bit. Busy-time accesses, every misaligned offset and every partial byte-enable mask are tried against a known word and checksum. A checksum overwrite followed by one write confirms that the fold starts from the written seed.

// File: rtl/hostmem_gate.sv
module hostmem_gate #(
  parameter int MEM_BYTES = 4096,
  parameter int HOST_BYTES = 2048,
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        busy_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [12:0] addr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rdata_o,
  output logic        err_o
);
  localparam int OFF_W = $clog2(MEM_BYTES);
  localparam int WORDS = MEM_BYTES / 4;
  localparam int IDX_W = OFF_W - 2;
  localparam logic [OFF_W:0] HOST_LIM = (OFF_W+1)'(HOST_BYTES);
  localparam logic [OFF_W-1:0] STAT_OFF = '0;
  localparam logic [OFF_W-1:0] CSUM_OFF = OFF_W'(4);

  logic [31:0] mem [WORDS];
  logic [31:0] mem_q, misc_q, csum_q;
  logic        rsp_q, err_q, from_mem_q;

  wire [OFF_W-1:0] off = addr_i[OFF_W-1:0];
  wire is_reg    = addr_i[OFF_W];
  wire aligned   = (off[1:0] == 2'b00) && (be_i == 4'hF);
  wire in_window = {1'b0, off} < HOST_LIM;
  wire hit_stat  = is_reg && (off == STAT_OFF);
  wire hit_csum  = is_reg && (off == CSUM_OFF);
  wire mem_ok    = req_i && !is_reg && aligned && in_window && !busy_i;
  wire reg_ok    = req_i && aligned && (hit_stat || hit_csum);
  wire [IDX_W-1:0] idx = off[OFF_W-1:2];

  function automatic logic [31:0] crc_fold(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] x;
    x = c ^ d;
    for (int k = 0; k < 32; k++) x = x[0] ? ((x >> 1) ^ POLY) : (x >> 1);
    return x;
  endfunction

  always_ff @(posedge clk_i) begin
    if (mem_ok) begin
      if (we_i) mem[idx] <= wdata_i;
      else      mem_q    <= mem[idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q      <= 1'b0;
      err_q      <= 1'b0;
      from_mem_q <= 1'b0;
      misc_q     <= '0;
      csum_q     <= '0;
    end else begin
      rsp_q      <= req_i;
      err_q      <= req_i && !(mem_ok || reg_ok);
      from_mem_q <= mem_ok && !we_i;
      misc_q     <= '0;
      if (reg_ok && !we_i) misc_q <= hit_stat ? {31'b0, busy_i} : csum_q;
      if (mem_ok && we_i)                csum_q <= crc_fold(csum_q, wdata_i);
      else if (reg_ok && we_i && hit_csum) csum_q <= wdata_i;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign err_o       = err_q;
  assign rdata_o     = from_mem_q ? mem_q : misc_q;
endmodule

module hostmem_gate_chk #(
  parameter int OFF_W = 12,
  parameter int HOST_BYTES = 2048
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        req_i,
  input logic        we_i,
  input logic [12:0] addr_i,
  input logic [3:0]  be_i,
  input logic        rsp_valid_o,
  input logic        err_o,
  input logic [31:0] rdata_o,
  input logic [31:0] csum
);
  localparam logic [OFF_W:0] LIM = (OFF_W+1)'(HOST_BYTES);
  wire mem_area = req_i && !addr_i[OFF_W];
  wire upper    = mem_area && ({1'b0, addr_i[OFF_W-1:0]} >= LIM);
  wire badform  = req_i && ((addr_i[1:0] != 2'b00) || (be_i != 4'hF));

  p_rsp_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) req_i |=> rsp_valid_o);
  p_no_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) !req_i |=> !rsp_valid_o);
  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) (rsp_valid_o && err_o) |-> (rdata_o == 32'h0));
  p_upper_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) upper |=> (err_o && rdata_o == 32'h0));
  p_upper_csum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) (upper && we_i) |=> $stable(csum));
  p_busy_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) (mem_area && busy_i) |=> err_o);
  p_busy_csum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) (mem_area && busy_i && we_i) |=> $stable(csum));
  p_badform_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) badform |=> (err_o && $stable(csum)));
endmodule

bind hostmem_gate hostmem_gate_chk #(.OFF_W($clog2(MEM_BYTES)), .HOST_BYTES(HOST_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .be_i(be_i), .rsp_valid_o(rsp_valid_o), .err_o(err_o),
  .rdata_o(rdata_o), .csum(csum_q)
);

// File: tb/hostmem_gate_tb.sv
module hostmem_gate_tb;
  logic clk = 0, rst_n = 0, busy = 0, req = 0, we = 0;
  logic [12:0] addr = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0, rdata;
  logic rsp_valid, err;
  int total = 0, bad = 0;
  logic [31:0] model [512];
  logic [31:0] csum_m = 0;
  logic [31:0] rd;
  logic e, v;

  always #4 clk = ~clk;

  hostmem_gate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rsp_valid_o(rsp_valid),
    .rdata_o(rdata), .err_o(err)
  );

  function automatic logic [31:0] crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] x = c ^ d;
    for (int k = 0; k < 32; k++) x = x[0] ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
    return x;
  endfunction

  function automatic logic [31:0] pat(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000 ^ i;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [12:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 0; we = 0; be = 4'hF;
    v = rsp_valid; rd = rdata; e = err;
    check("R8 response pulse", {31'b0, v}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 no response in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R9 idle after reset", {31'b0, rsp_valid}, 32'd0);
    acc(0, 13'h1004, 4'hF, 0); check("R9 checksum reset", rd, 32'h0);
    acc(0, 13'h1000, 4'hF, 0); check("R7 status idle", rd, 32'h0);

    for (int i = 0; i < 512; i++) begin
      model[i] = pat(i);
      acc(1, 13'(i * 4), 4'hF, model[i]);
      check("R1 write accepted", {31'b0, e}, 32'd0);
      csum_m = crc(csum_m, model[i]);
    end
    acc(0, 13'h1004, 4'hF, 0); check("R5 checksum after sweep", rd, csum_m);
    for (int i = 0; i < 512; i++) begin
      acc(0, 13'(i * 4), 4'hF, 0);
      check("R1 readback", rd, model[i]);
      check("R1 read no error", {31'b0, e}, 32'd0);
    end

    for (int a = 'h800; a < 'h1000; a += 'h40) begin
      acc(1, 13'(a), 4'hF, ~pat(a));
      check("R2 upper write error", {31'b0, e}, 32'd1);
      acc(0, 13'(a), 4'hF, 0);
      check("R2 upper read error", {31'b0, e}, 32'd1);
      check("R2 upper read zero", rd, 32'h0);
    end
    acc(0, 13'h1004, 4'hF, 0); check("R2 checksum unchanged", rd, csum_m);
    for (int i = 0; i < 512; i++) begin
      acc(0, 13'(i * 4), 4'hF, 0);
      check("R2 lower half intact", rd, model[i]);
    end

    busy = 1;
    acc(1, 13'h010, 4'hF, 32'hDEADBEEF); check("R3 busy write error", {31'b0, e}, 32'd1);
    acc(0, 13'h010, 4'hF, 0);
    check("R3 busy read error", {31'b0, e}, 32'd1);
    check("R3 busy read zero", rd, 32'h0);
    acc(0, 13'h1000, 4'hF, 0); check("R7 status busy", rd, 32'h1);
    acc(0, 13'h1004, 4'hF, 0); check("R3 checksum unchanged while busy", rd, csum_m);
    acc(1, 13'h1000, 4'hF, 32'hFFFFFFFF); check("R7 status write no error", {31'b0, e}, 32'd0);
    acc(0, 13'h1000, 4'hF, 0); check("R7 status after write", rd, 32'h1);
    busy = 0;
    acc(0, 13'h010, 4'hF, 0); check("R3 word kept", rd, model[4]);
    acc(0, 13'h1000, 4'hF, 0); check("R7 status idle again", rd, 32'h0);

    for (int o = 1; o < 4; o++) begin
      acc(1, 13'(32 + o), 4'hF, 32'h11111111);
      check("R4 misaligned write error", {31'b0, e}, 32'd1);
      acc(0, 13'(32 + o), 4'hF, 0);
      check("R4 misaligned read error", {31'b0, e}, 32'd1);
    end
    for (int b = 0; b < 15; b++) begin
      acc(1, 13'h020, 4'(b), 32'h22222222);
      check("R4 partial mask error", {31'b0, e}, 32'd1);
    end
    acc(0, 13'h020, 4'hF, 0); check("R4 word kept", rd, model[8]);
    acc(0, 13'h1004, 4'hF, 0); check("R4 checksum kept", rd, csum_m);

    acc(1, 13'h1004, 4'hF, 32'h12345678); check("R6 checksum write ok", {31'b0, e}, 32'd0);
    acc(0, 13'h1004, 4'hF, 0); check("R6 checksum readback", rd, 32'h12345678);
    csum_m = crc(32'h12345678, 32'hCAFEF00D);
    acc(1, 13'h000, 4'hF, 32'hCAFEF00D);
    acc(0, 13'h1004, 4'hF, 0); check("R5 fold from seed", rd, csum_m);
    busy = 1;
    acc(1, 13'h1004, 4'hF, 32'h0BADF00D); check("R6 write while busy", {31'b0, e}, 32'd0);
    acc(0, 13'h1004, 4'hF, 0); check("R6 read while busy", rd, 32'h0BADF00D);
    busy = 0;

    acc(0, 13'h1008, 4'hF, 0);
    check("R8 unmapped error", {31'b0, e}, 32'd1);
    check("R8 error data zero", rd, 32'h0);
    acc(1, 13'h1FFC, 4'hF, 1); check("R8 unmapped write error", {31'b0, e}, 32'd1);
    @(negedge clk);
    check("R8 no extra response", {31'b0, rsp_valid}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule